// File: doc/BRIEF.md
# Accumulator ALU with Status Word

This block is the arithmetic and logic stage of a small 8-bit processor datapath. Each cycle in which `op_valid` is high, it takes the accumulator value and a second operand and applies one of thirteen operations. The operations are binary add, add of the stored carry, increment, decimal add, AND, OR, XOR, complement, compare, and zero-filling shifts by one or four places in either direction. It registers the result and a one-cycle write pulse for the accumulator. It also updates a five-bit status word.

Each class of operation updates the status flags by its own fixed rule. Two strobes set and clear the interrupt-enable bit of the same word, independently of the ALU. The caller supplies the operands and writes the accumulator back; fetching operands, memory access and instruction sequencing belong to the surrounding core.

Decimal add expects packed-BCD operands with one of them pre-biased by adding 0x66 in binary. The block then removes the bias from every nibble that did not carry.

Top module: `acc_alu_flags`

## Requirements
- R1: After reset, `result` is 0, `result_wr` is 0 and `status` is 0.
- R2: Status layout: bit 0 is "positive" (1 when the result's MSB is 0), bit 1 carry, bit 2 zero (1 when the result is 0), bit 3 overflow, bit 4 interrupt enable.
- R3: `op_sel` codes: 0 add, 1 add stored carry, 2 increment, 3 decimal add, 4 AND, 5 OR, 6 XOR, 7 complement, 8 compare, 9 shift right 1, 10 shift right 4, 11 shift left 1, 12 shift left 4. An operation sampled on a rising edge shows its result and flags from that edge on. For every code except 8, `result_wr` is high for exactly that one cycle.
- R4: Add gives A+B modulo 256. Carry is the carry out of bit 7. Overflow is the carry into bit 7 XOR the carry out of it. Zero and positive follow the result.
- R5: Add stored carry gives A plus status bit 1, and increment gives A+1. Both use the R4 flag rule.
- R6: Decimal add forms the binary sum A+B, with carry and overflow as in R4. It then adds 0xA modulo 16 to each nibble that produced no carry out of itself. Zero and positive follow the adjusted result.
- R7: AND, OR, XOR with the operand and complement (A XOR 0xFF) clear carry and overflow; zero and positive follow the result.
- R8: Shifts fill with zeros and clear carry and overflow; zero follows the result. Right shifts always set positive; left shifts set it from the result's MSB.
- R9: Compare evaluates operand + NOT(A) + 1 and sets all four flags by the R4 rule. It leaves `result` unchanged and raises no `result_wr`.
- R10: `ien_set` sets status bit 4 and `ien_clr` clears it on the next edge; clear wins when both are high. ALU operations never change bit 4.
- R11: Codes 13 to 15 change neither `result` nor status bits 0 to 3, and raise no `result_wr`.
- R12: While `op_valid` is low, `result` and status bits 0 to 3 hold and `result_wr` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Execute the selected operation this cycle |
| op_sel | input | 4 | Operation code (R3) |
| acc_in | input | 8 | Accumulator value (A) |
| opnd_in | input | 8 | Second operand (B) |
| ien_set | input | 1 | Set interrupt enable |
| ien_clr | input | 1 | Clear interrupt enable |
| result | output | 8 | Last written result |
| result_wr | output | 1 | One-cycle accumulator write pulse |
| status | output | 5 | Status word (R2 layout) |

## Verification
Every output of this block sits one register from its inputs. A result, the write pulse, the four arithmetic flags and the interrupt-enable bit are therefore all due on the first rising edge after the operation or strobe is sampled. The write pulse falls again on the edge after that. The bench applies each operation on a falling edge, withdraws it on the next falling edge, and compares `result`, `result_wr` and `status` at that moment. It compares them against a model that recomputes sums with signed and unsigned integers rather than carry chains. Hold behaviour for compare, reserved codes and idle cycles is checked at the same point, against the value last written.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int OP_W   = 4;
  localparam int STAT_W = 5;
  localparam int FLG_POS = 0;
  localparam int FLG_CRY = 1;
  localparam int FLG_ZRO = 2;
  localparam int FLG_OVF = 3;
  localparam int FLG_IEN = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_LINK = 4'd1,
    OP_INC  = 4'd2,
    OP_DADD = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_COM  = 4'd7,
    OP_CMP  = 4'd8,
    OP_SHR1 = 4'd9,
    OP_SHR4 = 4'd10,
    OP_SHL1 = 4'd11,
    OP_SHL4 = 4'd12,
    OP_RSV0 = 4'd13,
    OP_RSV1 = 4'd14,
    OP_RSV2 = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {
    RULE_ARITH = 2'd0,
    RULE_LOGIC = 2'd1,
    RULE_SHR   = 2'd2,
    RULE_NONE  = 2'd3
  } flag_rule_e;

  // Flag nibble in status-word order: {ovf, zro, cry, pos}
  typedef struct packed {
    logic ovf;
    logic zro;
    logic cry;
    logic pos;
  } alu_flags_t;

  function automatic flag_rule_e rule_of(alu_op_e op);
    case (op)
      OP_ADD, OP_LINK, OP_INC, OP_DADD, OP_CMP: rule_of = RULE_ARITH;
      OP_AND, OP_OR, OP_XOR, OP_COM,
      OP_SHL1, OP_SHL4:                         rule_of = RULE_LOGIC;
      OP_SHR1, OP_SHR4:                         rule_of = RULE_SHR;
      default:                                  rule_of = RULE_NONE;
    endcase
  endfunction

  function automatic logic writes_acc(alu_op_e op);
    writes_acc = (rule_of(op) != RULE_NONE) && (op != OP_CMP);
  endfunction
endpackage

// File: rtl/acc_alu_adder.sv
module acc_alu_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  // Returns {carry out, carry into MSB, sum}
  function automatic logic [W+1:0] add_split(input logic [W-1:0] x,
                                             input logic [W-1:0] y,
                                             input logic         ci);
    logic [W-1:0] low;
    logic [1:0]   hi;
    low = {1'b0, x[W-2:0]} + {1'b0, y[W-2:0]} + {{(W-1){1'b0}}, ci};
    hi  = {1'b0, x[W-1]} + {1'b0, y[W-1]} + {1'b0, low[W-1]};
    add_split = {hi[1], low[W-1], hi[0], low[W-2:0]};
  endfunction

  logic [W+1:0] packed_out;
  logic         c_into_msb;

  assign packed_out = add_split(a, b, cin);
  assign sum        = packed_out[W-1:0];
  assign c_into_msb = packed_out[W];
  assign cout       = packed_out[W+1];
  assign ovf        = cout ^ c_into_msb;
endmodule

// File: rtl/acc_alu_bcd_adjust.sv
module acc_alu_bcd_adjust #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] sum,
  input  logic         cout,
  output logic [W-1:0] adj
);
  localparam int NIB = W / 4;

  logic [NIB-1:0] nib_co;

  for (genvar k = 0; k < NIB; k++) begin : g_nib
    if (k < NIB - 1) begin : g_inner
      // carry out of nibble k recovered from the shared sum
      assign nib_co[k] = sum[4*(k+1)] ^ a[4*(k+1)] ^ b[4*(k+1)];
    end else begin : g_top
      assign nib_co[k] = cout;
    end
    assign adj[4*k +: 4] = sum[4*k +: 4] + (nib_co[k] ? 4'h0 : 4'hA);
  end
endmodule

// File: rtl/acc_alu_logic_shift.sv
module acc_alu_logic_shift
  import acc_alu_pkg::*;
#(
  parameter int W          = 8,
  parameter int SHIFT_WIDE = 4
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  always_comb begin
    case (op)
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_COM:  y = a ^ {W{1'b1}};
      OP_SHR1: y = a >> 1;
      OP_SHR4: y = a >> SHIFT_WIDE;
      OP_SHL1: y = a << 1;
      OP_SHL4: y = a << SHIFT_WIDE;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/acc_alu_status_reg.sv
module acc_alu_status_reg
  import acc_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  alu_flags_t        flags_in,
  input  logic              ien_set,
  input  logic              ien_clr,
  output logic [STAT_W-1:0] w
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      w <= '0;
    end else begin
      if (upd) w[FLG_OVF:FLG_POS] <= flags_in;
      if (ien_clr)      w[FLG_IEN] <= 1'b0;
      else if (ien_set) w[FLG_IEN] <= 1'b1;
    end
  end
endmodule

// File: rtl/acc_alu_flags.sv
module acc_alu_flags
  import acc_alu_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int SHIFT_WIDE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [OP_W-1:0]   op_sel,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [DATA_W-1:0] opnd_in,
  input  logic              ien_set,
  input  logic              ien_clr,
  output logic [DATA_W-1:0] result,
  output logic              result_wr,
  output logic [STAT_W-1:0] status
);
  localparam int MSB = DATA_W - 1;

  alu_op_e     op;
  flag_rule_e  rule;
  logic [MSB:0] add_a, add_b, add_sum, dec_sum, ls_y, val;
  logic         add_cin, add_cout, add_ovf;
  logic         exec_fire, wr_next;
  alu_flags_t   flags_next;

  assign op   = alu_op_e'(op_sel);
  assign rule = rule_of(op);

  // shared adder operand steering
  always_comb begin
    add_a   = acc_in;
    add_b   = opnd_in;
    add_cin = 1'b0;
    case (op)
      OP_LINK: begin add_b = '0; add_cin = status[FLG_CRY]; end
      OP_INC:  begin add_b = '0; add_cin = 1'b1; end
      OP_CMP:  begin add_a = opnd_in; add_b = ~acc_in; add_cin = 1'b1; end
      default: ;
    endcase
  end

  acc_alu_adder #(.W(DATA_W)) u_add (
    .a(add_a), .b(add_b), .cin(add_cin),
    .sum(add_sum), .cout(add_cout), .ovf(add_ovf)
  );

  acc_alu_bcd_adjust #(.W(DATA_W)) u_bcd (
    .a(add_a), .b(add_b), .sum(add_sum), .cout(add_cout), .adj(dec_sum)
  );

  acc_alu_logic_shift #(.W(DATA_W), .SHIFT_WIDE(SHIFT_WIDE)) u_ls (
    .op(op), .a(acc_in), .b(opnd_in), .y(ls_y)
  );

  always_comb begin
    if (rule == RULE_ARITH) val = (op == OP_DADD) ? dec_sum : add_sum;
    else                    val = ls_y;
  end

  always_comb begin
    flags_next.ovf = (rule == RULE_ARITH) ? add_ovf  : 1'b0;
    flags_next.cry = (rule == RULE_ARITH) ? add_cout : 1'b0;
    flags_next.zro = (val == '0);
    flags_next.pos = (rule == RULE_SHR) ? 1'b1 : ~val[MSB];
  end

  assign exec_fire = op_valid && (rule != RULE_NONE);
  assign wr_next   = exec_fire && writes_acc(op);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result    <= '0;
      result_wr <= 1'b0;
    end else begin
      result_wr <= wr_next;
      if (wr_next) result <= val;
    end
  end

  acc_alu_status_reg u_w (
    .clk(clk), .rst_n(rst_n), .upd(exec_fire), .flags_in(flags_next),
    .ien_set(ien_set), .ien_clr(ien_clr), .w(status)
  );
endmodule

// File: rtl/acc_alu_flags_chk.sv
module acc_alu_flags_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic [3:0]        op_sel,
  input logic              ien_set,
  input logic              ien_clr,
  input logic [DATA_W-1:0] result,
  input logic              result_wr,
  input logic [4:0]        status,
  input logic              exec_fire
);
  assert_flags_track_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
    result_wr |-> (status[2] == (result == '0)) && (status[0] == ~result[DATA_W-1]));

  assert_write_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    exec_fire |=> (result_wr == ($past(op_sel) != 4'd8)));

  assert_logic_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel >= 4'd4 && op_sel <= 4'd7) |=> (!status[1] && !status[3]));

  assert_shr_positive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_sel == 4'd9 || op_sel == 4'd10)) |=> (status[0] && !status[1] && !status[3]));

  assert_cmp_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel == 4'd8) |=> (!result_wr && $stable(result)));

  assert_ien_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ien_clr |=> !status[4]);

  assert_ien_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_set && !ien_clr) |=> status[4]);

  assert_ien_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ien_set && !ien_clr) |=> $stable(status[4]));

  assert_reserved_inert_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel >= 4'd13) |=> ($stable(status[3:0]) && $stable(result) && !result_wr));

  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(status[3:0]) && $stable(result) && !result_wr));
endmodule

bind acc_alu_flags acc_alu_flags_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
  .ien_set(ien_set), .ien_clr(ien_clr), .result(result),
  .result_wr(result_wr), .status(status), .exec_fire(exec_fire)
);

// File: tb/sim_acc_alu_flags.sv
`timescale 1ns/1ps
module sim_acc_alu_flags;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [3:0] op_sel = 4'd0;
  logic [7:0] acc_in = 8'd0;
  logic [7:0] opnd_in = 8'd0;
  logic       ien_set = 1'b0;
  logic       ien_clr = 1'b0;
  logic [7:0] result;
  logic       result_wr;
  logic [4:0] status;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [7:0] exp_res = 8'd0;
  logic [4:0] exp_w = 5'd0;

  always #4 clk = ~clk;

  acc_alu_flags u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
    .acc_in(acc_in), .opnd_in(opnd_in), .ien_set(ien_set), .ien_clr(ien_clr),
    .result(result), .result_wr(result_wr), .status(status)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int sgn(input logic [7:0] v);
    return v[7] ? int'(v) - 256 : int'(v);
  endfunction

  // Independent model: integer sums, range tests for overflow
  task automatic model(input int op, input logic [7:0] a, input logic [7:0] b,
                       input logic cflag, output logic [7:0] r, output logic wr,
                       output logic [3:0] f);
    int s, ss, lo, hi;
    logic cy, ov, shr, lo_c, hi_c;
    cy = 0; ov = 0; shr = 0; wr = 1; r = 8'd0; s = 0; ss = 0;
    case (op)
      0, 1, 2, 3: begin
        int addend, saddend;
        addend  = (op == 1) ? int'(cflag) : (op == 2) ? 1 : int'(b);
        saddend = (op == 0 || op == 3) ? sgn(b) : addend;
        s  = int'(a) + addend;
        ss = sgn(a) + saddend;
        r  = 8'(s);
        cy = (s > 255);
        ov = (ss > 127) || (ss < -128);
        if (op == 3) begin
          lo   = int'(a[3:0]) + int'(b[3:0]);
          lo_c = (lo > 15);
          hi   = int'(a[7:4]) + int'(b[7:4]) + int'(lo_c);
          hi_c = (hi > 15);
          r[3:0] = 4'((lo + (lo_c ? 0 : 10)) % 16);
          r[7:4] = 4'((hi + (hi_c ? 0 : 10)) % 16);
        end
      end
      4: r = a & b;
      5: r = a | b;
      6: r = a ^ b;
      7: r = ~a;
      8: begin
        s  = int'(b) + (255 - int'(a)) + 1;
        ss = sgn(b) - sgn(a);
        r  = 8'(s);
        cy = (s > 255);
        ov = (ss > 127) || (ss < -128);
        wr = 0;
      end
      9:  begin r = a >> 1; shr = 1; end
      10: begin r = a >> 4; shr = 1; end
      11: r = a << 1;
      12: r = a << 4;
      default: wr = 0;
    endcase
    f = {ov, (r == 8'd0), cy, (shr ? 1'b1 : ~r[7])};
  endtask

  // Drive on a falling edge, withdraw on the next, compare there
  task automatic do_op(input string req, input int op, input logic [7:0] a,
                       input logic [7:0] b, input logic s_ie, input logic c_ie);
    logic [7:0] r; logic wr; logic [3:0] f;
    model(op, a, b, exp_w[1], r, wr, f);
    @(negedge clk);
    op_valid = 1'b1; op_sel = 4'(op); acc_in = a; opnd_in = b;
    ien_set = s_ie; ien_clr = c_ie;
    @(negedge clk);
    op_valid = 1'b0; ien_set = 1'b0; ien_clr = 1'b0;
    if (wr) exp_res = r;
    if (op < 13) exp_w[3:0] = f;
    if (c_ie) exp_w[4] = 1'b0;
    else if (s_ie) exp_w[4] = 1'b1;
    check(req, "result", int'(result), int'(exp_res));
    check(req, "result_wr", int'(result_wr), int'(wr));
    check(req, "status", int'(status), int'(exp_w));
  endtask

  task automatic t_reset;
    check("R1", "result", int'(result), 0);
    check("R1", "result_wr", int'(result_wr), 0);
    check("R1", "status", int'(status), 0);
  endtask

  task automatic t_add;
    do_op("R4", 0, 8'h12, 8'h34, 0, 0);
    do_op("R4", 0, 8'h7F, 8'h01, 0, 0);   // overflow, negative
    do_op("R4", 0, 8'hFF, 8'h01, 0, 0);   // carry, zero
    do_op("R4", 0, 8'h80, 8'h80, 0, 0);   // carry, overflow, zero
    do_op("R2", 0, 8'h00, 8'h05, 0, 0);   // positive flag layout
  endtask

  task automatic t_link_inc;
    do_op("R5", 0, 8'hF0, 8'h20, 0, 0);   // sets carry
    do_op("R5", 1, 8'h10, 8'h00, 0, 0);   // +1 from carry
    do_op("R5", 1, 8'h10, 8'hAA, 0, 0);   // carry now 0, operand ignored
    do_op("R5", 2, 8'hFF, 8'h00, 0, 0);   // wraps to zero
    do_op("R5", 2, 8'h7F, 8'h00, 0, 0);   // overflow
  endtask

  task automatic t_dadd;
    do_op("R6", 3, 8'h8E, 8'h19, 0, 0);   // 28+19 biased -> 47
    do_op("R6", 3, 8'hFF, 8'h99, 0, 0);   // 99+99 biased -> 98 carry
    do_op("R6", 3, 8'h66, 8'h00, 0, 0);   // 00+00 biased -> 00, no carry
  endtask

  task automatic t_logic;
    do_op("R7", 4, 8'hF0, 8'h3C, 0, 0);
    do_op("R7", 4, 8'h0F, 8'hF0, 0, 0);   // zero
    do_op("R7", 5, 8'h01, 8'h80, 0, 0);
    do_op("R7", 6, 8'hAA, 8'hAA, 0, 0);
    do_op("R7", 7, 8'h5A, 8'h00, 0, 0);
    do_op("R7", 7, 8'hFF, 8'h00, 0, 0);
  endtask

  task automatic t_shift;
    do_op("R8", 0, 8'hFF, 8'h01, 0, 0);   // carry set first
    do_op("R8", 9, 8'h81, 8'h00, 0, 0);
    do_op("R8", 10, 8'h0F, 8'h00, 0, 0);  // zero, still positive
    do_op("R8", 11, 8'hC1, 8'h00, 0, 0);
    do_op("R8", 12, 8'h09, 8'h00, 0, 0);
    do_op("R8", 11, 8'h80, 8'h00, 0, 0);  // zero
  endtask

  task automatic t_cmp;
    do_op("R9", 0, 8'h21, 8'h00, 0, 0);
    do_op("R9", 8, 8'h05, 8'h05, 0, 0);
    do_op("R9", 8, 8'h05, 8'h03, 0, 0);
    do_op("R9", 8, 8'h01, 8'h80, 0, 0);   // overflow
    do_op("R9", 8, 8'h00, 8'h7F, 0, 0);
  endtask

  task automatic t_ien;
    do_op("R10", 13, 8'h00, 8'h00, 1, 0);
    do_op("R10", 7, 8'h00, 8'h00, 0, 0);  // ALU op keeps enable
    do_op("R10", 0, 8'h01, 8'h01, 1, 1);  // clear wins
    do_op("R10", 13, 8'h00, 8'h00, 1, 0);
    do_op("R10", 13, 8'h00, 8'h00, 0, 1);
  endtask

  task automatic t_reserved;
    do_op("R11", 0, 8'h80, 8'h80, 0, 0);
    do_op("R11", 13, 8'h01, 8'h02, 0, 0);
    do_op("R11", 14, 8'hFF, 8'hFF, 0, 0);
    do_op("R11", 15, 8'h00, 8'h00, 0, 0);
  endtask

  task automatic t_idle;
    do_op("R12", 6, 8'h3C, 8'h0F, 0, 0);
    @(negedge clk);
    op_sel = 4'd0; acc_in = 8'hFF; opnd_in = 8'hFF;
    @(negedge clk);
    @(negedge clk);
    check("R12", "result", int'(result), int'(exp_res));
    check("R12", "result_wr", int'(result_wr), 0);
    check("R12", "status", int'(status), int'(exp_w));
    check("R3", "pulse width", int'(result_wr), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_add();
    t_link_inc();
    t_dadd();
    t_logic();
    t_shift();
    t_cmp();
    t_ien();
    t_reserved();
    t_idle();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule